// File: doc/BRIEF.md
# PWM Slice with Gated Fractional Divider

A single pulse-width modulation slice that drives two outputs, A and B, from one shared 16-bit counter. The counter advances on ticks from a fractional divider whose ratio is an 8-bit integer with a 4-bit fraction. Each output compares the counter against its own level and may be inverted. The counter either wraps from its top value back to zero or, in phase-correct mode, runs up and then down again. Each completed period produces a one-cycle wrap pulse, which the surrounding chip routes to an interrupt flag and a DMA request.

Channel B can stop acting as an output and become an input instead. In that role it either gates the divider, so that the divider runs only while B is high, or feeds it with B's rising or falling edges. B is synchronised through two flops before it is used. Software programs the slice through a simple word write port. It can load the counter directly, and it can ask for a single extra step (advance) or a single skipped step (retard). Both requests clear themselves in hardware once they have been applied.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter is 0, wrap_o is low, both levels are 0, top is 0xFFFF, the divider ratio is 1.0, the slice is disabled in free-running mode, and both pending flags are low.
- R2: Register map (addr_i): 0 control, 1 divider, 2 counter, 3 levels, 4 top. In normal mode an enabled slice steps the counter 0,1,..,top,0 with one step per divider tick.
- R3: wrap_o is high for exactly one cycle, in the cycle in which the counter shows 0 after a wrap.
- R4: Divider register bits [11:4] hold the integer part and bits [3:0] hold the sixteenths. Over N gated cycles the counter advances floor(16*N/ratio16) steps, for example 8 steps in 20 cycles at 2.5 and 3 steps in 9 cycles at 3.0.
- R5: Before inversion, an output is high while the counter is below its level. Level A sits in wdata_i[15:0] and level B in wdata_i[31:16], written under be_i[0] and be_i[1] respectively. A level of 0 gives a constant low output and a level above top gives a constant high output.
- R6: Control bit 2 inverts A and control bit 3 inverts B.
- R7: Control bit 0 enables the slice. While it is clear the counter holds its value. A write to address 2 loads the counter.
- R8: Control bit 1 selects phase-correct mode, in which the counter runs 0..top..0. The wrap pulse appears when the counter reaches 0 while counting down.
- R9: Control bits [5:4] select the divider source: 0 free running, 1 B high, 2 B rising, 3 B falling. In mode 1 the counter advances only while the synchronised B is high, two cycles behind b_i. b_oe_o is high only in mode 0.
- R10: In modes 2 and 3 each rising or falling edge of B, respectively, gives one divider tick. A steady level of B gives none.
- R11: Setting control bit 6 while the slice is enabled makes the counter take one extra step on the next clock. adv_pend_o then clears.
- R12: Setting control bit 7 while the slice is enabled swallows the next divider tick. ret_pend_o clears when that tick is swallowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| be_i | input | 2 | Half-word enables: bit 0 lower, bit 1 upper |
| b_i | input | 1 | Channel B pin input |
| a_o | output | 1 | Channel A waveform |
| b_o | output | 1 | Channel B waveform |
| b_oe_o | output | 1 | Channel B output enable |
| count_o | output | 16 | Current counter value |
| wrap_o | output | 1 | Wrap event pulse |
| adv_pend_o | output | 1 | Advance request pending |
| ret_pend_o | output | 1 | Retard request pending |

## Verification
The hardest cases to reach are the phase steps. Advance and retard only show up as a one-count difference against a known tick rate. To isolate them, the stimulus first parks the counter in B-gated mode with B held low, so no ticks arrive, and then issues an advance. That leaves exactly one step to observe. It then switches to free running with a retard request in the same write, so the swallowed tick is the very first one. The gated mode is also exercised across its two-cycle synchroniser delay, at both the start and the end of a B-high window.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  typedef enum logic [1:0] {
    DIV_FREE = 2'd0,
    DIV_GATE = 2'd1,
    DIV_RISE = 2'd2,
    DIV_FALL = 2'd3
  } div_mode_e;

  // packed MSB first: mode[5:4], inv_b[3], inv_a[2], pc[1], en[0]
  typedef struct packed {
    div_mode_e mode;
    logic      inv_b;
    logic      inv_a;
    logic      pc;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int ADV_BIT = 6;
  localparam int RET_BIT = 7;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DIV  = 1;
  localparam int ADDR_CNT  = 2;
  localparam int ADDR_LVL  = 3;
  localparam int ADDR_TOP  = 4;
endpackage

// File: rtl/pwm_b_input.sv
module pwm_b_input
  import pwm_slice_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      b_i,
  input  div_mode_e mode_i,
  output logic      gate_o
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;
  logic            b_s;

  assign b_s = sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], b_i};
      last_q <= b_s;
    end
  end

  always_comb begin
    unique case (mode_i)
      DIV_FREE: gate_o = 1'b1;
      DIV_GATE: gate_o = b_s;
      DIV_RISE: gate_o = b_s & ~last_q;
      default:  gate_o = ~b_s & last_q;
    endcase
  end
endmodule

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int IW = 8,
  parameter int FW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IW+FW-1:0] div_i,
  output logic             tick_o
);
  localparam int DW = IW + FW;
  localparam logic [DW-1:0] ONE = DW'(1) << FW;

  logic [DW:0] acc_q, sum, dv;

  // integer part of 0 is treated as ratio 1.0
  assign dv     = (div_i < ONE) ? {1'b0, ONE} : {1'b0, div_i};
  assign sum    = acc_q + {1'b0, ONE};
  assign tick_o = en_i && (sum >= dv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= tick_o ? sum - dv : sum;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pc_i,
  input  logic [CW-1:0] top_i,
  input  logic          tick_i,
  input  logic          adv_i,
  input  logic          ret_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o,
  output logic          adv_done_o,
  output logic          ret_done_o
);
  typedef struct packed {
    logic          wrap;
    logic          down;
    logic [CW-1:0] cnt;
  } step_t;

  function automatic step_t step(input logic [CW-1:0] c, input logic d,
                                 input logic [CW-1:0] top, input logic pc);
    step_t s;
    s = '{wrap: 1'b0, down: 1'b0, cnt: c + 1'b1};
    if (!pc) begin
      if (c >= top) s = '{wrap: 1'b1, down: 1'b0, cnt: '0};
    end else if (!d) begin
      if (c >= top) begin
        s.cnt  = (c == '0) ? '0 : c - 1'b1;
        s.down = 1'b1;
        s.wrap = (s.cnt == '0);
      end
    end else if (c != '0) begin
      s.cnt  = c - 1'b1;
      s.down = 1'b1;
      s.wrap = (s.cnt == '0);
    end
    return s;
  endfunction

  logic  down_q;
  step_t s1, s2, nxt;

  always_comb begin
    s1         = step(count_o, down_q, top_i, pc_i);
    s2         = step(s1.cnt, s1.down, top_i, pc_i);
    nxt        = '{wrap: 1'b0, down: down_q, cnt: count_o};
    adv_done_o = 1'b0;
    ret_done_o = 1'b0;
    if (en_i && !ld_i) begin
      if (adv_i) begin
        adv_done_o = 1'b1;
        nxt        = tick_i ? s2 : s1;
        nxt.wrap   = s1.wrap | (tick_i & s2.wrap);
      end else if (ret_i && tick_i) begin
        ret_done_o = 1'b1;
      end else if (tick_i) begin
        nxt = s1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      down_q  <= 1'b0;
      wrap_o  <= 1'b0;
    end else if (ld_i) begin
      count_o <= ld_val_i;
      down_q  <= 1'b0;
      wrap_o  <= 1'b0;
    end else begin
      count_o <= nxt.cnt;
      down_q  <= nxt.down;
      wrap_o  <= nxt.wrap;
    end
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CW   = 16,
  parameter int IW   = 8,
  parameter int FW   = 4,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2*CW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  input  logic          b_i,
  output logic          a_o,
  output logic          b_o,
  output logic          b_oe_o,
  output logic [CW-1:0] count_o,
  output logic          wrap_o,
  output logic          adv_pend_o,
  output logic          ret_pend_o
);
  localparam int DW = IW + FW;
  localparam logic [DW-1:0] DIV_ONE = DW'(1) << FW;

  ctrl_t         ctrl_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] top_q;
  logic [CW-1:0] lvl_q [2];
  logic          adv_q, ret_q;
  logic          ctrl_wr, cnt_ld, div_wr, top_wr, lvl_wr;
  logic          gate, tick, adv_done, ret_done;
  logic [1:0]    inv, pin;

  assign ctrl_wr = we_i && be_i[0] && (addr_i == AW'(ADDR_CTRL));
  assign div_wr  = we_i && be_i[0] && (addr_i == AW'(ADDR_DIV));
  assign cnt_ld  = we_i && be_i[0] && (addr_i == AW'(ADDR_CNT));
  assign top_wr  = we_i && be_i[0] && (addr_i == AW'(ADDR_TOP));
  assign lvl_wr  = we_i && (addr_i == AW'(ADDR_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= DIV_ONE;
      top_q  <= '1;
      adv_q  <= 1'b0;
      ret_q  <= 1'b0;
      for (int i = 0; i < 2; i++) lvl_q[i] <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      adv_q <= (adv_q & ~adv_done) | (ctrl_wr & wdata_i[ADV_BIT]);
      ret_q <= (ret_q & ~ret_done) | (ctrl_wr & wdata_i[RET_BIT]);
      if (div_wr) div_q <= wdata_i[DW-1:0];
      if (top_wr) top_q <= wdata_i[CW-1:0];
      if (lvl_wr && be_i[0]) lvl_q[0] <= wdata_i[CW-1:0];
      if (lvl_wr && be_i[1]) lvl_q[1] <= wdata_i[2*CW-1:CW];
    end
  end

  pwm_b_input #(.SYNC(SYNC)) u_bin (
    .clk_i, .rst_ni, .b_i, .mode_i(ctrl_q.mode), .gate_o(gate)
  );

  pwm_frac_div #(.IW(IW), .FW(FW)) u_div (
    .clk_i, .rst_ni, .en_i(ctrl_q.en & gate), .div_i(div_q), .tick_o(tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.en), .pc_i(ctrl_q.pc), .top_i(top_q), .tick_i(tick),
    .adv_i(adv_q), .ret_i(ret_q), .ld_i(cnt_ld), .ld_val_i(wdata_i[CW-1:0]),
    .count_o, .wrap_o, .adv_done_o(adv_done), .ret_done_o(ret_done)
  );

  assign inv = {ctrl_q.inv_b, ctrl_q.inv_a};
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    assign pin[ch] = (count_o < lvl_q[ch]) ^ inv[ch];
  end

  assign a_o        = pin[0];
  assign b_o        = pin[1];
  assign b_oe_o     = (ctrl_q.mode == DIV_FREE);
  assign adv_pend_o = adv_q;
  assign ret_pend_o = ret_q;
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          pc_i,
  input logic          ld_i,
  input logic          ctrl_wr_i,
  input logic [CW-1:0] top_i,
  input logic [CW-1:0] count_i,
  input logic          wrap_i,
  input logic          adv_i,
  input logic          ret_i
);
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pc_i && !ld_i && !adv_i && count_i < top_i) |=>
      (count_i == $past(count_i) || count_i == $past(count_i) + 1'b1));

  a_r3_wrap_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !$past(adv_i)) |-> (count_i == '0));

  a_r7_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_i) |=> $stable(count_i));

  a_r11_adv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && en_i && !ld_i && !ctrl_wr_i) |=> !adv_i);

  a_r12_ret_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !adv_i && en_i && !ld_i) |=> $stable(count_i));
endmodule

bind pwm_slice pwm_slice_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni,
  .en_i(ctrl_q.en), .pc_i(ctrl_q.pc), .ld_i(cnt_ld), .ctrl_wr_i(ctrl_wr),
  .top_i(top_q), .count_i(count_o), .wrap_i(wrap_o),
  .adv_i(adv_q), .ret_i(ret_q)
);

// File: tb/pwm_slice_test.sv
module pwm_slice_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  be_i = '0;
  logic        b_i = 1'b0;
  logic        a_o, b_o, b_oe_o, wrap_o, adv_pend_o, ret_pend_o;
  logic [15:0] count_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    exp;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_slice uut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .be_i, .b_i,
    .a_o, .b_o, .b_oe_o, .count_o, .wrap_o, .adv_pend_o, .ret_pend_o
  );

  // driver side: queue an expectation
  task automatic expect_item(input string req, input int exp);
    sb_q.push_back('{req: req, exp: exp});
  endtask

  // monitor side: pop and compare against observed value
  task automatic observe(input int act);
    item_t it;
    it = sb_q.pop_front();
    n_checks++;
    if (act != it.exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", it.req, act, it.exp);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    expect_item(req, exp);
    observe(act);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] be);
    we_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      b_i = 1'b1; cyc(3);
      b_i = 1'b0; cyc(3);
    end
    cyc(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int c;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 count", count_o, 0);
    chk("R1 wrap", wrap_o, 0);
    chk("R1 outputs", {a_o, b_o}, 0);
    chk("R1 b_oe", b_oe_o, 1);
    chk("R1 pend", {adv_pend_o, ret_pend_o}, 0);

    wr(3'd4, 32'd9, 2'b01);
    wr(3'd3, {16'd7, 16'd3}, 2'b11);
    wr(3'd0, 32'h01, 2'b01);
    cyc(5);
    chk("R2 count", count_o, 5);
    chk("R5 a below", a_o, 0);
    chk("R5 b below", b_o, 1);
    cyc(4);
    chk("R2 top", count_o, 9);
    chk("R3 no wrap", wrap_o, 0);
    cyc(1);
    chk("R2 wrapped", count_o, 0);
    chk("R3 wrap pulse", wrap_o, 1);
    cyc(1);
    chk("R3 pulse one cycle", wrap_o, 0);
    chk("R5 a high", a_o, 1);

    wr(3'd3, {16'd2, 16'd15}, 2'b10);
    chk("R5 half write count", count_o, 2);
    chk("R5 b level 2", b_o, 0);
    chk("R5 a kept", a_o, 1);

    wr(3'd0, 32'h05, 2'b01);
    chk("R6 inv a", a_o, 1);
    chk("R6 b plain", b_o, 0);

    wr(3'd3, {16'd20, 16'd0}, 2'b11);
    for (int i = 0; i < 12; i++) begin
      chk("R5 level0 inverted", a_o, 1);
      chk("R5 level above top", b_o, 1);
      cyc(1);
    end
    wr(3'd0, 32'h09, 2'b01);
    chk("R6 inv b", b_o, 0);

    wr(3'd0, 32'h00, 2'b01);
    c = count_o;
    cyc(5);
    chk("R7 hold disabled", count_o, c);
    wr(3'd2, 32'd4, 2'b01);
    chk("R7 load", count_o, 4);

    wr(3'd4, 32'hFFFF, 2'b01);
    wr(3'd2, 32'd0, 2'b01);
    wr(3'd1, 32'h28, 2'b01);
    wr(3'd0, 32'h01, 2'b01);
    cyc(20);
    chk("R4 ratio 2.5", count_o, 8);
    wr(3'd0, 32'h00, 2'b01);
    wr(3'd1, 32'h30, 2'b01);
    wr(3'd2, 32'd0, 2'b01);
    wr(3'd0, 32'h01, 2'b01);
    cyc(9);
    chk("R4 ratio 3.0", count_o, 3);

    wr(3'd0, 32'h00, 2'b01);
    wr(3'd1, 32'h10, 2'b01);
    wr(3'd4, 32'd4, 2'b01);
    wr(3'd2, 32'd0, 2'b01);
    wr(3'd0, 32'h03, 2'b01);
    cyc(5);
    chk("R8 down", count_o, 3);
    cyc(3);
    chk("R8 bottom", count_o, 0);
    chk("R8 wrap", wrap_o, 1);
    cyc(1);
    chk("R8 up again", count_o, 1);
    chk("R8 wrap gone", wrap_o, 0);

    wr(3'd0, 32'h00, 2'b01);
    wr(3'd4, 32'hFFFF, 2'b01);
    wr(3'd2, 32'd0, 2'b01);
    wr(3'd0, 32'h11, 2'b01);
    chk("R9 b_oe off", b_oe_o, 0);
    cyc(4);
    chk("R9 b low", count_o, 0);
    b_i = 1'b1;
    cyc(10);
    chk("R9 sync delay", count_o, 8);
    b_i = 1'b0;
    cyc(10);
    chk("R9 gate closes", count_o, 10);

    wr(3'd0, 32'h21, 2'b01);
    pulses(5);
    chk("R10 rising", count_o, 15);
    wr(3'd0, 32'h31, 2'b01);
    pulses(5);
    chk("R10 falling", count_o, 20);

    wr(3'd0, 32'h11, 2'b01);
    wr(3'd0, 32'h51, 2'b01);
    chk("R11 pending", adv_pend_o, 1);
    cyc(1);
    chk("R11 step", count_o, 21);
    chk("R11 cleared", adv_pend_o, 0);
    cyc(3);
    chk("R11 single", count_o, 21);

    wr(3'd0, 32'h81, 2'b01);
    chk("R12 pending", ret_pend_o, 1);
    cyc(10);
    chk("R12 skipped", count_o, 30);
    chk("R12 cleared", ret_pend_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule